// File: doc/BRIEF.md
# Serial-Addressed Write Port Controller

This block drives the write side of a field or line delay memory. It runs entirely in the write clock domain and feeds a dual-port RAM with a word address, a data word and a write strobe. The RAM array, the read side and any refresh logic are outside the block.

A one-cycle load strobe starts the sequence. The start address then arrives one bit per clock on a serial pin, least significant bit first. A settle period follows. After that the block advances a write pointer under a write gate. A separate write mask decides whether each advancing cycle also writes. The gate freezes the pointer when it is low. The mask only suppresses the write, and the pointer still steps. Every command reaches the RAM port through a fixed pipeline. A sticky error flag records any breach of the load-and-start protocol.

The controller has four states. `WS_IDLE` holds after reset. `WS_LOAD` shifts in the address bits. `WS_SETTLE` counts the post-load delay. `WS_RUN` accepts writes. A load strobe moves any state to `WS_LOAD`, and a strobe during `WS_LOAD` restarts the shift. `WS_LOAD` moves to `WS_SETTLE` on the last address bit. `WS_SETTLE` moves to `WS_RUN` after `POST_DLY` edges.

Top module: `wr_port_ctrl`

## Requirements
- R1: After `rst_n` is released, `ram_wen` and `proto_err` are 0. Gate and mask activity has no effect on the RAM port until a load sequence completes.
- R2: The `ADDR_W` edges that follow the load-strobe edge sample `addr_sdi`, least significant bit first. The bit sampled on the first of these edges is bit 0. The start pointer is the loaded value modulo `DEPTH`.
- R3: In `WS_RUN`, an edge that samples `we`=1 and `ie`=1 writes `din` at the current pointer, and the pointer then increments.
- R4: In `WS_RUN`, an edge that samples `we`=1 and `ie`=0 writes nothing, and the pointer still increments.
- R5: An edge that samples `we`=0 writes nothing and leaves the pointer unchanged, whatever `ie` is.
- R6: Call the sampling edge k. The command sampled on edge k is presented on `ram_wen`, `ram_addr` and `ram_din` in the cycle after edge k+`LAT`-1, so the RAM commits it on edge k+`LAT`.
- R7: After location `DEPTH`-1, the pointer steps to 0.
- R8: Writing starts only after `ADDR_W`+`POST_DLY` edges have followed the load strobe. A `we`=1 sampled inside that window is ignored and raises `proto_err`. A correct sequence leaves the flag at 0.
- R9: A load strobe raises `proto_err` in two cases: `we` is 1 on the strobe edge, or fewer than `PRE_LOW` consecutive edges with `we`=0 came before it.
- R10: The first rise of `we` in `WS_RUN` after a load must last at least 2 edges. Otherwise `proto_err` rises.
- R11: A load strobe that arrives in `WS_RUN` after fewer than `MIN_ACT` active edges (`we`=1 and `ie`=1) since the previous strobe raises `proto_err`.
- R12: `proto_err` stays at 1 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_rst_stb | input | 1 | Load strobe that starts a serial address load |
| addr_sdi | input | 1 | Serial start-address bit, least significant bit first |
| we | input | 1 | Write gate; when low, the pointer freezes |
| ie | input | 1 | Write mask; when low, the write is suppressed and the pointer still steps |
| din | input | DATA_W | Data word to write |
| ram_addr | output | PTR_W | RAM write address |
| ram_din | output | DATA_W | RAM write data |
| ram_wen | output | 1 | RAM write strobe |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The bench loads a value larger than the depth, which checks the modulo and the bit order: a loader that shifted MSB first or skipped the reduction would write to the wrong location. It interleaves masked cycles and gated cycles, and starts a run two words before the end so that the pointer wraps. A design that confused gate and mask, or wrapped at a power of two, would produce an address sequence the scoreboard rejects. Each protocol breach is driven on its own after a fresh reset: a gate raised during settle, the gate high on the strobe, too short a quiet period, a one-edge first rise and a burst that is too short. A design that missed any of these would leave the flag low. A design that let the early gate through would also emit a write the scoreboard never expected.

// File: rtl/wrctl_pkg.sv
package wrctl_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_LOAD   = 2'd1,
        WS_SETTLE = 2'd2,
        WS_RUN    = 2'd3
    } wst_e;
endpackage

// File: rtl/wrctl_seq.sv
module wrctl_seq
    import wrctl_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DEPTH    = 1114112,
    parameter int PTR_W    = 21,
    parameter int POST_DLY = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             addr_bit,
    input  logic             we,
    input  logic             ie,
    output wst_e             state_o,
    output logic             cmd_valid,
    output logic [PTR_W-1:0] cmd_addr
);
    localparam int CNT_MAX = (ADDR_W > POST_DLY) ? ADDR_W : POST_DLY;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    wst_e              state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] shreg_q;
    logic [ADDR_W-1:0] full;
    logic [31:0]       full_mod;
    logic [PTR_W-1:0]  wptr_q;
    logic              load_done, advance;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (strobe) state_d = WS_LOAD;
            WS_LOAD:   if (strobe) state_d = WS_LOAD;
                       else if (cnt_q == CNT_W'(ADDR_W - 1)) state_d = WS_SETTLE;
            WS_SETTLE: if (strobe) state_d = WS_LOAD;
                       else if (cnt_q == CNT_W'(POST_DLY - 1)) state_d = WS_RUN;
            WS_RUN:    if (strobe) state_d = WS_LOAD;
            default:   state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    assign full      = {addr_bit, shreg_q[ADDR_W-1:1]};
    assign full_mod  = 32'(full) % 32'(DEPTH);
    assign load_done = (state_q == WS_LOAD) && !strobe && (cnt_q == CNT_W'(ADDR_W - 1));
    assign advance   = (state_q == WS_RUN) && we && !strobe;

    // phase counter, address shifter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            wptr_q  <= '0;
        end else begin
            if (strobe || load_done || !(state_q inside {WS_LOAD, WS_SETTLE}))
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
            if (state_q == WS_LOAD && !strobe)
                shreg_q <= full;
            if (load_done)
                wptr_q <= full_mod[PTR_W-1:0];
            else if (advance)
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        cmd_valid = advance && ie;
        cmd_addr  = wptr_q;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_RUN && !we && !strobe) |=> $stable(wptr_q));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_RUN && we && !strobe && wptr_q != LAST)
        |=> (wptr_q == $past(wptr_q) + PTR_W'(1)));
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_RUN && we && !strobe && wptr_q == LAST) |=> (wptr_q == '0));
    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, wptr_q} < (PTR_W + 1)'(DEPTH)));
endmodule

// File: rtl/wrctl_guard.sv
module wrctl_guard
    import wrctl_pkg::*;
#(
    parameter int PRE_LOW = 4,
    parameter int MIN_ACT = 231
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic we,
    input  logic ie,
    input  wst_e state,
    output logic viol
);
    localparam int LO_W  = $clog2(PRE_LOW + 1);
    localparam int ACT_W = $clog2(MIN_ACT + 1);

    logic [LO_W-1:0]  lo_q;
    logic [ACT_W-1:0] act_q;
    logic             pend_q, chk_q, viol_q, bad, run;

    assign run = (state == WS_RUN);

    always_comb begin
        bad = (strobe && (we || lo_q < LO_W'(PRE_LOW)))
           || (strobe && run && act_q < ACT_W'(MIN_ACT))
           || (!strobe && (state == WS_LOAD || state == WS_SETTLE) && we)
           || (chk_q && !we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
            chk_q  <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            if (we)                          lo_q <= '0;
            else if (lo_q < LO_W'(PRE_LOW))  lo_q <= lo_q + LO_W'(1);
            if (strobe)                      act_q <= '0;
            else if (run && we && ie && act_q < ACT_W'(MIN_ACT))
                                             act_q <= act_q + ACT_W'(1);
            if (strobe)                      pend_q <= 1'b1;
            else if (run && we)              pend_q <= 1'b0;
            chk_q  <= !strobe && run && pend_q && we;
            viol_q <= viol_q | bad;
        end
    end

    assign viol = viol_q;

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);
endmodule

// File: rtl/wrctl_pipe.sv
module wrctl_pipe #(
    parameter int LAT    = 4,
    parameter int PTR_W  = 21,
    parameter int DATA_W = 24,
    parameter int DEPTH  = 1114112
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [PTR_W-1:0]  in_a,
    input  logic [DATA_W-1:0] in_d,
    output logic              out_v,
    output logic [PTR_W-1:0]  out_a,
    output logic [DATA_W-1:0] out_d
);
    for (genvar i = 0; i < LAT; i++) begin : g_stage
        logic              v;
        logic [PTR_W-1:0]  a;
        logic [DATA_W-1:0] d;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0; a <= '0; d <= '0;
                end else begin
                    v <= in_v; a <= in_a; d <= in_d;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0; a <= '0; d <= '0;
                end else begin
                    v <= g_stage[i-1].v; a <= g_stage[i-1].a; d <= g_stage[i-1].d;
                end
            end
        end
    end

    assign out_v = g_stage[LAT-1].v;
    assign out_a = g_stage[LAT-1].a;
    assign out_d = g_stage[LAT-1].d;

    p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> ({1'b0, out_a} < (PTR_W + 1)'(DEPTH)));
endmodule

// File: rtl/wr_port_ctrl.sv
module wr_port_ctrl
    import wrctl_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int ADDR_W   = 21,
    parameter int DEPTH    = 1114112,
    parameter int LAT      = 4,
    parameter int POST_DLY = 160,
    parameter int PRE_LOW  = 4,
    parameter int MIN_ACT  = 231,
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rst_stb,
    input  logic              addr_sdi,
    input  logic              we,
    input  logic              ie,
    input  logic [DATA_W-1:0] din,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_din,
    output logic              ram_wen,
    output logic              proto_err
);
    wst_e             state;
    logic             cmd_valid;
    logic [PTR_W-1:0] cmd_addr;

    wrctl_seq #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .POST_DLY(POST_DLY)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe(wr_rst_stb), .addr_bit(addr_sdi),
        .we(we), .ie(ie), .state_o(state), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr)
    );

    wrctl_guard #(.PRE_LOW(PRE_LOW), .MIN_ACT(MIN_ACT)) u_guard (
        .clk(clk), .rst_n(rst_n), .strobe(wr_rst_stb), .we(we), .ie(ie),
        .state(state), .viol(proto_err)
    );

    wrctl_pipe #(.LAT(LAT), .PTR_W(PTR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_v(cmd_valid), .in_a(cmd_addr), .in_d(din),
        .out_v(ram_wen), .out_a(ram_addr), .out_d(ram_din)
    );
endmodule

// File: tb/sim_wr_port_ctrl.sv
`timescale 1ns/1ps
module sim_wr_port_ctrl;
    localparam int DW = 24, AW = 21, DEPTH = 50, LAT = 4, PD = 6, PL = 4, MA = 5;
    localparam int PW = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, sdi = 1'b0, we = 1'b0, ie = 1'b0;
    logic [DW-1:0] din = '0;
    logic [PW-1:0] ram_addr;
    logic [DW-1:0] ram_din;
    logic ram_wen, proto_err;

    wr_port_ctrl #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH), .LAT(LAT),
                   .POST_DLY(PD), .PRE_LOW(PL), .MIN_ACT(MA)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_rst_stb(stb), .addr_sdi(sdi), .we(we), .ie(ie),
        .din(din), .ram_addr(ram_addr), .ram_din(ram_din), .ram_wen(ram_wen),
        .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    typedef struct {
        int unsigned addr;
        logic [DW-1:0] data;
        int cyc;
        string req;
    } exp_t;
    exp_t q[$];

    int cyc = 0, nchk = 0, nfail = 0;
    bit done = 0, run_m = 0;
    int unsigned ptr_m = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1; nchk++; nfail++;
            $display("FAIL watchdog: actual cycle %0d, expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expected writes and compares
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && ram_wen) begin
            if (q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R8: actual write at addr %0d, expected no write", ram_addr);
            end else begin
                e = q.pop_front();
                chk({e.req, " cycle"}, cyc, e.cyc);
                chk({e.req, " addr"}, int'(ram_addr), int'(e.addr));
                chk({e.req, " data"}, int'(ram_din), int'(e.data));
            end
        end
    end

    // driver: one clock per call, pushes predicted writes
    task automatic step(input logic w, input logic i, input logic [DW-1:0] d, input string req);
        we = w; ie = i; din = d;
        if (run_m && w && i) q.push_back('{ptr_m, d, cyc + LAT, req});
        if (run_m && w) ptr_m = (ptr_m == DEPTH - 1) ? 0 : ptr_m + 1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b0, '0, "");
    endtask

    task automatic load(input int unsigned a, input logic stb_we, input int bad);
        run_m = 0;
        stb = 1'b1;
        step(stb_we, 1'b0, '0, "R2");
        stb = 1'b0;
        for (int b = 0; b < AW; b++) begin
            sdi = a[b];
            step(1'b0, 1'b0, '0, "R2");
        end
        sdi = 1'b0;
        for (int s = 0; s < PD; s++) step(s == bad, s == bad, 24'hBAD, "R8");
        run_m = 1;
        ptr_m = a % DEPTH;
    endtask

    task automatic hard_reset();
        idle(LAT + 1);
        chk("R6 drained", q.size(), 0);
        rst_n = 1'b0;
        run_m = 0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and no writes before a load
        chk("R1 ram_wen", ram_wen, 0);
        chk("R1 proto_err", proto_err, 0);
        repeat (3) step(1'b1, 1'b1, 24'h111111, "R1");
        idle(LAT + 1);
        chk("R1 ram_wen idle", ram_wen, 0);
        chk("R1 proto_err idle", proto_err, 0);

        // R2/R3/R4/R5/R6: 123 mod 50 = 23
        idle(PL);
        load(123, 1'b0, -1);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 24'hA00000 + k, "R3");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 24'hEEEEEE, "R5");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 24'hDDDDDD, "R4");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 24'hB00000 + k, "R6");
        idle(LAT + 1);
        chk("R8 no false flag", proto_err, 0);

        // R7: 197 mod 50 = 47, wraps after 49
        idle(PL);
        load(197, 1'b0, -1);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 24'hC00000 + k, "R7");
        idle(LAT + 1);
        chk("R7 no false flag", proto_err, 0);

        // R8: gate raised during settle
        hard_reset();
        chk("R1 flag cleared", proto_err, 0);
        idle(PL);
        load(30, 1'b0, 2);
        chk("R8 early gate", proto_err, 1);
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 24'h300000 + k, "R8");
        idle(LAT + 1);
        chk("R12 sticky", proto_err, 1);

        // R9: gate high on strobe
        hard_reset();
        idle(PL);
        load(5, 1'b1, -1);
        chk("R9 gate on strobe", proto_err, 1);

        // R9: quiet period too short
        hard_reset();
        idle(2);
        load(5, 1'b0, -1);
        chk("R9 short quiet", proto_err, 1);

        // R10: first rise lasts one edge
        hard_reset();
        idle(PL);
        load(10, 1'b0, -1);
        chk("R10 before", proto_err, 0);
        step(1'b1, 1'b1, 24'h0A0A0A, "R10");
        step(1'b0, 1'b0, '0, "R10");
        chk("R10 short rise", proto_err, 1);

        // R11: burst too short before next strobe
        hard_reset();
        idle(PL);
        load(0, 1'b0, -1);
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 24'h500000 + k, "R11");
        idle(PL);
        chk("R11 before", proto_err, 0);
        load(0, 1'b0, -1);
        chk("R11 short burst", proto_err, 1);
        idle(3);
        chk("R12 still set", proto_err, 1);

        idle(LAT + 1);
        chk("R6 queue empty", q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule